// File: doc/BRIEF.md
# Reference Frequency Range Monitor

This block supervises two timing reference inputs against a stable master clock and drives one flag per reference. A flag reads high when its reference runs too fast, runs too slow, or has stopped. The limit is a tolerance in parts per million around a nominal rate. Each reference has its own 2-bit rate selector, which picks one of four telecom rates as that input's nominal frequency.

Each reference is first brought into the master clock domain. The block then counts that reference's active edges over a gate of a fixed number of master clock cycles. At the end of each gate, the count is checked against an acceptance window computed at elaboration for the selected rate, and the flag is updated. The two channels are fully independent: each has its own gate timer, edge counter, selector history and flag.

A system uses the flags to decide whether a reference is fit to serve as a synchronization source. The gate length sets how finely the tolerance can be resolved. It is a parameter, so a deployment can trade reaction time against resolution.

Top module: `ref_freq_monitor`

## Requirements
- R1: The two channels are independent. Each reference input, with its own selector, drives only its own out-of-range flag.
- R2: Selector codes map to nominal rates as follows: 0 = 8 kHz, 1 = 1.544 MHz, 2 = 2.048 MHz, 3 = 19.44 MHz. Each rate is a parameter (NOM_HZ_0 to NOM_HZ_3, indexed by code).
- R3: N is the nominal count, round(NOM_HZ × GATE_CYCLES / MCLK_HZ). D is floor(N × TOL_PPM / 10^6). At the end of a gate, the flag becomes 1 when the counted edges fall outside [N − D − 1, N + D + 1], and 0 when they fall inside it. The extra count on each side absorbs the ±1 count that gate phase alone can cause.
- R4: For codes 0, 1 and 2, the block counts falling edges of the reference. For code 3, it counts rising edges. The reference passes through a two-flop synchronizer, so a level must be held for at least two master cycles to register.
- R5: A gate lasts GATE_CYCLES master cycles. The flag is written only in the cycle after a gate's last cycle, and holds its value at all other times.
- R6: A change of a channel's selector discards that channel's gate in progress. A fresh gate starts on the clock edge where the change is seen, so the next flag update comes GATE_CYCLES cycles after that edge.
- R7: When a selector change lands on the same clock edge as a gate's last cycle, the selector change wins: the gate is discarded and the flag keeps its value.
- R8: A gate in which no active edge was counted sets the flag to 1 for every selector code.
- R9: Reset is synchronous and active low on `rst_n`. Reset clears both flags to 0 and restarts both gates. Both flags stay 0 until each channel completes its first full gate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock, the counting time base |
| rst_n | input | 1 | Synchronous reset, active low |
| ref0_in | input | 1 | Reference input, channel 0 (asynchronous) |
| ref1_in | input | 1 | Reference input, channel 1 (asynchronous) |
| ref0_rate | input | 2 | Nominal rate code for channel 0 |
| ref1_rate | input | 2 | Nominal rate code for channel 1 |
| ref0_off_freq | output | 1 | Channel 0 out-of-range flag |
| ref1_off_freq | output | 1 | Channel 1 out-of-range flag |

## Verification
Two functions can fall on the same clock edge: a selector change, and the close of the gate in which the flag would be updated. To provoke this, the bench changes a selector exactly GATE_CYCLES edges after a known restart. The rate on either side of that change is chosen so that an update would flip the flag. The flag is then judged 20 cycles later: it must still hold its old value. A similar test puts a selector change in the middle of a gate. There, the flag must stay unchanged at the instant the abandoned gate would have closed, and must take its new value only one full gate after the change.

// File: rtl/freqmon_pkg.sv
package freqmon_pkg;

    // Rate codes; the encoding is what the selector pins carry.
    typedef enum logic [1:0] {
        RATE_8K     = 2'd0,
        RATE_1544K  = 2'd1,
        RATE_2048K  = 2'd2,
        RATE_19440K = 2'd3
    } rate_e;

    typedef enum logic {
        EDGE_FALL = 1'b0,
        EDGE_RISE = 1'b1
    } edge_e;

    // Acceptance window in counted edges per gate.
    typedef struct packed {
        logic [63:0] lo;
        logic [63:0] hi;
    } win_t;

    localparam int unsigned NUM_RATES = 4;
    localparam longint unsigned PPM_SCALE = 64'd1_000_000;

    // Low-rate framing and clock rates count falling edges; the fastest counts rising edges.
    function automatic edge_e edge_for(rate_e r);
        return (r == RATE_19440K) ? EDGE_RISE : EDGE_FALL;
    endfunction

    function automatic longint unsigned nominal_count(
        longint unsigned nom_hz,
        longint unsigned mclk_hz,
        longint unsigned gate
    );
        return (nom_hz * gate + mclk_hz / 2) / mclk_hz;
    endfunction

    function automatic win_t make_window(
        longint unsigned nom_hz,
        longint unsigned mclk_hz,
        longint unsigned gate,
        longint unsigned tol_ppm
    );
        longint unsigned nc;
        longint unsigned dev;
        win_t w;
        nc   = nominal_count(nom_hz, mclk_hz, gate);
        dev  = (nc * tol_ppm) / PPM_SCALE;
        w.lo = (nc > dev + 1) ? (nc - dev - 1) : 64'd0;
        w.hi = nc + dev + 1;
        return w;
    endfunction

endpackage

// File: rtl/freqmon_sync_edge.sv
module freqmon_sync_edge
    import freqmon_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  din,
    input  edge_e mode,
    output logic  pulse
);
    localparam int STAGES = 2;

    logic [STAGES-1:0] sync_q;
    logic              last_q;
    logic              rise;
    logic              fall;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            last_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], din};
            last_q <= sync_q[STAGES-1];
        end
    end

    assign rise  = sync_q[STAGES-1] & ~last_q;
    assign fall  = ~sync_q[STAGES-1] & last_q;
    assign pulse = (mode == EDGE_RISE) ? rise : fall;

endmodule

// File: rtl/freqmon_window.sv
module freqmon_window
    import freqmon_pkg::*;
#(
    parameter logic [NUM_RATES-1:0][31:0] NOM_TAB     = '0,
    parameter int unsigned                MCLK_HZ     = 1,
    parameter longint unsigned            GATE_CYCLES = 1,
    parameter int unsigned                TOL_PPM     = 0
) (
    input  rate_e       rate,
    output logic [63:0] lo,
    output logic [63:0] hi
);
    logic [63:0] lo_tab [NUM_RATES];
    logic [63:0] hi_tab [NUM_RATES];

    for (genvar r = 0; r < NUM_RATES; r++) begin : g_rate
        localparam win_t W = make_window(
            longint'(NOM_TAB[r]), longint'(MCLK_HZ), GATE_CYCLES, longint'(TOL_PPM));
        assign lo_tab[r] = W.lo;
        assign hi_tab[r] = W.hi;
    end

    assign lo = lo_tab[rate];
    assign hi = hi_tab[rate];

endmodule

// File: rtl/freqmon_channel.sv
module freqmon_channel
    import freqmon_pkg::*;
#(
    parameter logic [NUM_RATES-1:0][31:0] NOM_TAB     = '0,
    parameter int unsigned                MCLK_HZ     = 1,
    parameter longint unsigned            GATE_CYCLES = 2,
    parameter int unsigned                TOL_PPM     = 0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ref_in,
    input  logic [1:0] rate_sel,
    output logic       off_freq
);
    localparam int CW = $clog2(GATE_CYCLES + 1);
    localparam logic [CW-1:0] GATE_LAST = CW'(GATE_CYCLES - 1);

    rate_e         rate_q;
    logic [CW-1:0] gate_cnt;
    logic [CW-1:0] edge_cnt;
    logic [CW-1:0] edge_total;
    logic          edge_pulse;
    logic          sel_chg;
    logic          gate_last;
    logic          verdict;
    logic [63:0]   win_lo;
    logic [63:0]   win_hi;
    logic          first_done;

    freqmon_sync_edge u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (ref_in),
        .mode  (edge_for(rate_q)),
        .pulse (edge_pulse)
    );

    freqmon_window #(
        .NOM_TAB     (NOM_TAB),
        .MCLK_HZ     (MCLK_HZ),
        .GATE_CYCLES (GATE_CYCLES),
        .TOL_PPM     (TOL_PPM)
    ) u_win (
        .rate (rate_q),
        .lo   (win_lo),
        .hi   (win_hi)
    );

    assign sel_chg    = (rate_e'(rate_sel) != rate_q);
    assign gate_last  = (gate_cnt == GATE_LAST);
    assign edge_total = edge_cnt + CW'(edge_pulse);
    assign verdict    = (edge_total == '0)
                     || (64'(edge_total) < win_lo)
                     || (64'(edge_total) > win_hi);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rate_q     <= rate_e'(rate_sel);
            gate_cnt   <= '0;
            edge_cnt   <= '0;
            off_freq   <= 1'b0;
            first_done <= 1'b0;
        end else begin
            rate_q <= rate_e'(rate_sel);
            if (sel_chg) begin
                gate_cnt <= '0;
                edge_cnt <= '0;
            end else if (gate_last) begin
                gate_cnt   <= '0;
                edge_cnt   <= '0;
                off_freq   <= verdict;
                first_done <= 1'b1;
            end else begin
                gate_cnt <= gate_cnt + 1'b1;
                edge_cnt <= edge_total;
            end
        end
    end

    // R5
    gate_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gate_cnt <= GATE_LAST);

    // R5
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !gate_last |=> $stable(off_freq));

    // R6
    restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sel_chg |=> (gate_cnt == '0 && edge_cnt == '0));

    // R7
    collision_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_chg && gate_last) |=> $stable(off_freq));

    // R8
    empty_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_last && !sel_chg && edge_cnt == '0 && !edge_pulse) |=> off_freq);

    // R9
    reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !first_done |-> !off_freq);

endmodule

// File: rtl/ref_freq_monitor.sv
module ref_freq_monitor
    import freqmon_pkg::*;
#(
    parameter int unsigned     MCLK_HZ     = 155_520_000,
    parameter longint unsigned GATE_CYCLES = 64'd5_000_000_000,
    parameter int unsigned     TOL_PPM     = 12,
    parameter int unsigned     NOM_HZ_0    = 8_000,
    parameter int unsigned     NOM_HZ_1    = 1_544_000,
    parameter int unsigned     NOM_HZ_2    = 2_048_000,
    parameter int unsigned     NOM_HZ_3    = 19_440_000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ref0_in,
    input  logic       ref1_in,
    input  logic [1:0] ref0_rate,
    input  logic [1:0] ref1_rate,
    output logic       ref0_off_freq,
    output logic       ref1_off_freq
);
    localparam int NUM_REF = 2;
    localparam logic [NUM_RATES-1:0][31:0] NOM_TAB =
        {NOM_HZ_3, NOM_HZ_2, NOM_HZ_1, NOM_HZ_0};

    logic [NUM_REF-1:0]      ref_vec;
    logic [NUM_REF-1:0][1:0] rate_vec;
    logic [NUM_REF-1:0]      flag_vec;

    assign ref_vec  = {ref1_in, ref0_in};
    assign rate_vec = {ref1_rate, ref0_rate};

    for (genvar c = 0; c < NUM_REF; c++) begin : g_chan
        freqmon_channel #(
            .NOM_TAB     (NOM_TAB),
            .MCLK_HZ     (MCLK_HZ),
            .GATE_CYCLES (GATE_CYCLES),
            .TOL_PPM     (TOL_PPM)
        ) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .ref_in   (ref_vec[c]),
            .rate_sel (rate_vec[c]),
            .off_freq (flag_vec[c])
        );
    end

    assign ref0_off_freq = flag_vec[0];
    assign ref1_off_freq = flag_vec[1];

endmodule

// File: tb/ref_freq_monitor_tb.sv
module ref_freq_monitor_tb;
    localparam int G   = 2000;
    localparam int M   = 1000;
    localparam int TOL = 25000;
    localparam int NOM [4] = '{20, 50, 100, 125};

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic       rst_n = 1'b0;
    logic [1:0] rate0 = 2'd0;
    logic [1:0] rate1 = 2'd0;
    logic       burst_mode = 1'b0;
    logic       bst_lvl = 1'b0;
    logic       gen_en [2] = '{1'b0, 1'b0};
    int         per    [2] = '{50, 50};
    int         cnt    [2] = '{0, 0};
    logic       gen_lvl[2] = '{1'b0, 1'b0};
    logic       ref0, ref1, flag0, flag1;
    int         errors = 0;
    int         checks = 0;
    bit         done = 1'b0;

    assign ref0 = burst_mode ? bst_lvl : gen_lvl[0];
    assign ref1 = gen_lvl[1];

    ref_freq_monitor #(
        .MCLK_HZ(M), .GATE_CYCLES(G), .TOL_PPM(TOL),
        .NOM_HZ_0(20), .NOM_HZ_1(50), .NOM_HZ_2(100), .NOM_HZ_3(125)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .ref0_in(ref0), .ref1_in(ref1),
        .ref0_rate(rate0), .ref1_rate(rate1),
        .ref0_off_freq(flag0), .ref1_off_freq(flag1)
    );

    always @(negedge clk) begin
        for (int i = 0; i < 2; i++) begin
            if (!gen_en[i]) begin
                cnt[i] <= 0; gen_lvl[i] <= 1'b0;
            end else begin
                cnt[i]     <= (cnt[i] + 1 >= per[i]) ? 0 : cnt[i] + 1;
                gen_lvl[i] <= (cnt[i] < per[i] / 2) ? 1'b0 : 1'b1;
            end
        end
    end

    function automatic int nc_of(int code);
        return (NOM[code] * G + M / 2) / M;
    endfunction
    function automatic bit exp_flag(int code, int count);
        int n, d;
        n = nc_of(code);
        d = (n * TOL) / 1000000;
        return (count == 0) || (count < n - d - 1) || (count > n + d + 1);
    endfunction
    function automatic bit ambiguous(int code, int p);
        return exp_flag(code, G / p) != exp_flag(code, (G + p - 1) / p);
    endfunction

    task automatic chk(string req, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0b expected=%0b", req, act, exp);
        end
    endtask
    task automatic wait_n(int n);
        repeat (n) @(negedge clk);
    endtask
    task automatic restart_one(int ch, logic [1:0] tgt);
        @(negedge clk);
        if (ch == 0) rate0 = tgt ^ 2'd1; else rate1 = tgt ^ 2'd1;
        @(negedge clk);
        if (ch == 0) rate0 = tgt; else rate1 = tgt;
    endtask
    task automatic restart_both(logic [1:0] t0, logic [1:0] t1);
        @(negedge clk);
        rate0 = t0 ^ 2'd1; rate1 = t1 ^ 2'd1;
        @(negedge clk);
        rate0 = t0; rate1 = t1;
    endtask
    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        #(20 * 190000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        int s0, s1, p0, p1;
        void'($urandom(32'd4242));
        wait_n(5);
        rst_n = 1'b1;
        // R9: quiet before first gate; R8: dead references flagged after it
        wait_n(G - 30);
        chk("R9 ch0", flag0, 1'b0);
        chk("R9 ch1", flag1, 1'b0);
        wait_n(50);
        chk("R8 ch0", flag0, 1'b1);
        chk("R8 ch1", flag1, 1'b1);

        // R3 directed boundaries on ch1, code 1 (window 97..103); R1 ch0 matched
        gen_en[0] = 1'b1; gen_en[1] = 1'b1;
        per[0] = 50; per[1] = 19;
        wait_n(100);
        restart_both(2'd0, 2'd1);
        wait_n(G + 20);
        chk("R3 fast ch1", flag1, 1'b1);
        chk("R1 ch0 matched", flag0, 1'b0);
        per[1] = 21;
        wait_n(100);
        restart_one(1, 2'd1);
        wait_n(G + 20);
        chk("R3 slow ch1", flag1, 1'b1);
        per[1] = 20;
        wait_n(100);
        restart_one(1, 2'd1);
        wait_n(G + 20);
        chk("R3 exact ch1", flag1, 1'b0);

        // R6: mid-gate discard on ch0
        restart_one(0, 2'd0);
        wait_n(G + 20);
        chk("R6 setup", flag0, 1'b0);
        rate0 = 2'd1;
        wait_n(G - 10);
        chk("R6 old gate discarded", flag0, 1'b0);
        wait_n(20);
        chk("R6 new gate result", flag0, 1'b1);

        // R7: selector change on a gate's last cycle
        rate0 = 2'd0;
        wait_n(G);
        rate0 = 2'd1;
        wait_n(20);
        chk("R7 collision keeps flag", flag0, 1'b1);

        // R4: code 3 counts rising edges (257 rises, 258 falls; window 243..257)
        burst_mode = 1'b1; bst_lvl = 1'b1;
        wait_n(10);
        restart_one(0, 2'd3);
        wait_n(10);
        repeat (257) begin
            bst_lvl = 1'b0; wait_n(2);
            bst_lvl = 1'b1; wait_n(2);
        end
        bst_lvl = 1'b0;
        wait_n(G + 20 - 10 - 257 * 4);
        chk("R4 rising count code 3", flag0, 1'b0);

        // R4: code 0 counts falling edges (42 falls, 43 rises; window 38..42)
        wait_n(10);
        restart_one(0, 2'd0);
        wait_n(10);
        repeat (42) begin
            bst_lvl = 1'b1; wait_n(2);
            bst_lvl = 1'b0; wait_n(2);
        end
        bst_lvl = 1'b1;
        wait_n(G + 20 - 10 - 42 * 4);
        chk("R4 falling count code 0", flag0, 1'b0);
        burst_mode = 1'b0;

        // R1 R2 R3: constrained random on both channels
        for (int it = 0; it < 30; it++) begin
            do begin
                s0 = $urandom_range(0, 3); p0 = $urandom_range(6, 60);
            end while (ambiguous(s0, p0));
            do begin
                s1 = $urandom_range(0, 3); p1 = $urandom_range(6, 60);
            end while (ambiguous(s1, p1));
            per[0] = p0; per[1] = p1;
            wait_n(100);
            restart_both(2'(s0), 2'(s1));
            wait_n(G + 20);
            chk("R1 R2 R3 ch0", flag0, exp_flag(s0, G / p0));
            chk("R1 R2 R3 ch1", flag1, exp_flag(s1, G / p1));
        end

        done = 1'b1;
        summary();
        $finish;
    end
endmodule